// File: doc/BRIEF.md
# Bank-Aware Prefetch Issue Arbiter

This block sits between a hardware prefetcher and the miss-tracking registers of a core. Prefetches arrive with a target address and a DRAM bank number, and each one is parked in a small queue that belongs to its bank. Each cycle the arbiter offers at most one parked prefetch to the miss-tracking registers. It does not simply send the oldest prefetch. It prefers the bank that currently has the fewest requests outstanding, so that the misses in flight are spread over many banks and the memory controller can overlap them.

The arbiter keeps one occupancy counter per bank, driven by allocate and free events reported by the miss-tracking registers for demand and prefetch misses alike. A bank's oldest prefetch may be offered only while that bank's occupancy does not exceed a send threshold. The threshold follows a measured prefetch accuracy. At the end of every measurement interval the block compares the useful-prefetch count against the issued-prefetch count it gathered and places the result in one of three accuracy classes. Poorly performing prefetchers are therefore held to few outstanding requests per bank. Accurate prefetchers are allowed to fill the banks.

Top module: `prefetch_issue_arb`

## Requirements
- R1: Prefetches that target the same bank are offered on the issue port in the order they were accepted, with `issueAddr` carrying the stored address and `issueBank` the bank.
- R2: `pfReady` is low while the bank named on `pfBank` already holds FIFO_DEPTH prefetches. A prefetch presented while `pfReady` is low is not stored and is never offered.
- R3: A bank's occupancy rises by one on `allocValid` and falls by one on `freeValid` for that bank. Both events in one cycle leave it unchanged. A free at occupancy zero is ignored, and the count never exceeds MSHR_ENTRIES.
- R4: A bank's oldest prefetch is eligible only when that bank's occupancy is less than or equal to the current send threshold.
- R5: Among eligible banks, the one with the smallest occupancy is offered. Ties go to the lowest bank number.
- R6: `issueValid` stays low while `mshrFreeAvail` is low.
- R7: The send threshold is 1 in the low accuracy class (below 40 %), 7 in the middle class (40 % up to but not including 85 %) and 27 in the high class (85 % and above). After reset the class is low.
- R8: Every INTERVAL cycles after reset, the class is recomputed from the useful and issued counts gathered during that interval, and both counts restart from zero. An interval with no issued prefetch keeps the previous class. An event in the cycle that closes an interval counts toward the next one.
- R9: A prefetch leaves its queue only in a cycle with `issueValid` and `issueReady` both high. While `issueReady` is low, the offered prefetch stays on the port.
- R10: After reset no prefetch is offered, and `pfReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfValid | input | 1 | Prefetcher presents a prefetch |
| pfAddr | input | ADDR_W | Prefetch line address |
| pfBank | input | $clog2(NUM_BANKS) | DRAM bank of the prefetch |
| pfReady | output | 1 | Target bank queue can accept |
| allocValid | input | 1 | A miss-tracking entry was allocated |
| allocBank | input | $clog2(NUM_BANKS) | Bank of the allocated entry |
| freeValid | input | 1 | A miss-tracking entry was released |
| freeBank | input | $clog2(NUM_BANKS) | Bank of the released entry |
| mshrFreeAvail | input | 1 | At least one miss-tracking entry is free |
| usefulEvt | input | 1 | One prefetch proved useful this cycle |
| issuedEvt | input | 1 | One prefetch was issued to memory this cycle |
| issueValid | output | 1 | A prefetch is offered |
| issueReady | input | 1 | Miss-tracking registers take the offered prefetch |
| issueAddr | output | ADDR_W | Address of the offered prefetch |
| issueBank | output | $clog2(NUM_BANKS) | Bank of the offered prefetch |

## Verification
A single bank loaded three deep, with the issue port stalled and then released, shows whether arrival order and holding under backpressure are kept. A queue filled to capacity and then pushed again shows whether an extra request can leak in. Several banks with mixed occupancy, shaped by single, paired and underflowing allocate/free events, tell the minimum-occupancy choice apart from index order or arrival order, and show the lowest-index tiebreak and threshold blocking. Accuracy is exercised with ratios exactly on the 40 % and 85 % boundaries, with a high interval followed by a low one (which exposes counts that are not cleared), and with an empty interval (which must keep the old class). Each class is probed by raising one bank's occupancy to the threshold and then one above it.

// File: rtl/pia_pkg.sv
package pia_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;   // accept the presented prefetch into its bank queue
    logic pop;    // remove the head of the selected bank queue
  } arbStrobes_t;

  // Accuracy class latched at each interval boundary
  typedef enum logic [1:0] {
    ACC_LOW  = 2'd0,
    ACC_MID  = 2'd1,
    ACC_HIGH = 2'd2
  } accLevel_t;

endpackage

// File: rtl/pia_acc_est.sv
module pia_acc_est
  import pia_pkg::*;
#(
  parameter int INTERVAL = 100000,
  parameter int LOW_PCT  = 40,
  parameter int HIGH_PCT = 85
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      usefulEvt,
  input  logic      issuedEvt,
  output accLevel_t level
);
  localparam int CNT_W = $clog2(INTERVAL + 1);
  localparam int TMR_W = $clog2(INTERVAL);
  localparam int MW    = CNT_W + 8;

  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] usefulCnt, issuedCnt;
  logic             tick;
  logic [MW-1:0]    scaledUseful, lowBound, highBound;
  accLevel_t        nextLevel;

  assign tick = (tmr == TMR_W'(INTERVAL - 1));

  // Ratio compared by cross multiplication, no divider needed
  always_comb begin
    scaledUseful = MW'(usefulCnt) * MW'(100);
    lowBound     = MW'(issuedCnt) * MW'(LOW_PCT);
    highBound    = MW'(issuedCnt) * MW'(HIGH_PCT);
    if (scaledUseful < lowBound)       nextLevel = ACC_LOW;
    else if (scaledUseful < highBound) nextLevel = ACC_MID;
    else                               nextLevel = ACC_HIGH;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr       <= '0;
      usefulCnt <= '0;
      issuedCnt <= '0;
      level     <= ACC_LOW;
    end else begin
      tmr       <= tick ? '0 : tmr + TMR_W'(1);
      usefulCnt <= tick ? CNT_W'(usefulEvt) : usefulCnt + CNT_W'(usefulEvt);
      issuedCnt <= tick ? CNT_W'(issuedEvt) : issuedCnt + CNT_W'(issuedEvt);
      if (tick && (issuedCnt != '0)) level <= nextLevel;
    end
  end
endmodule

// File: rtl/pia_ctrl.sv
module pia_ctrl
  import pia_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int OCC_W     = 6,
  parameter int BANK_W    = 3,
  parameter int TH_LOW    = 1,
  parameter int TH_MID    = 7,
  parameter int TH_HIGH   = 27
) (
  input  accLevel_t                       level,
  input  logic [NUM_BANKS-1:0][OCC_W-1:0] occVec,
  input  logic [NUM_BANKS-1:0]            emptyVec,
  input  logic [NUM_BANKS-1:0]            fullVec,
  input  logic                            pfValid,
  input  logic [BANK_W-1:0]               pfBank,
  input  logic                            mshrFreeAvail,
  input  logic                            issueReady,
  output arbStrobes_t                     strobes,
  output logic [BANK_W-1:0]               selBank,
  output logic                            issueValid,
  output logic                            pfReady,
  output logic [OCC_W-1:0]                sendThresh
);
  logic [NUM_BANKS-1:0] eligible;
  logic                 found;
  logic [OCC_W-1:0]     bestOcc;

  always_comb begin
    unique case (level)
      ACC_HIGH: sendThresh = OCC_W'(TH_HIGH);
      ACC_MID:  sendThresh = OCC_W'(TH_MID);
      default:  sendThresh = OCC_W'(TH_LOW);
    endcase
  end

  // Eligibility gate and minimum-occupancy search; strict compare keeps lowest index on ties
  always_comb begin
    found   = 1'b0;
    selBank = '0;
    bestOcc = '1;
    for (int b = 0; b < NUM_BANKS; b++) begin
      eligible[b] = !emptyVec[b] && (occVec[b] <= sendThresh);
      if (eligible[b] && (!found || (occVec[b] < bestOcc))) begin
        found   = 1'b1;
        selBank = BANK_W'(b);
        bestOcc = occVec[b];
      end
    end
  end

  assign pfReady      = !fullVec[pfBank];
  assign issueValid   = found && mshrFreeAvail;
  assign strobes.push = pfValid && pfReady;
  assign strobes.pop  = issueValid && issueReady;
endmodule

// File: rtl/pia_datapath.sv
module pia_datapath
  import pia_pkg::*;
#(
  parameter int NUM_BANKS    = 8,
  parameter int DEPTH        = 4,
  parameter int ADDR_W       = 32,
  parameter int OCC_W        = 6,
  parameter int BANK_W       = 3,
  parameter int MSHR_ENTRIES = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  arbStrobes_t                      strobes,
  input  logic [BANK_W-1:0]                pushBank,
  input  logic [ADDR_W-1:0]                pushAddr,
  input  logic [BANK_W-1:0]                popBank,
  input  logic                             allocValid,
  input  logic [BANK_W-1:0]                allocBank,
  input  logic                             freeValid,
  input  logic [BANK_W-1:0]                freeBank,
  output logic [NUM_BANKS-1:0][ADDR_W-1:0] headAddr,
  output logic [NUM_BANKS-1:0]             emptyVec,
  output logic [NUM_BANKS-1:0]             fullVec,
  output logic [NUM_BANKS-1:0][OCC_W-1:0]  occVec
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [ADDR_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rdPtr, wrPtr;
    logic [CNT_W-1:0]  cnt;
    logic              pushHere, popHere, incHere, decHere;
    logic [OCC_W-1:0]  occ;

    assign pushHere = strobes.push && (pushBank == BANK_W'(b));
    assign popHere  = strobes.pop  && (popBank  == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (pushHere) mem[wrPtr] <= pushAddr;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rdPtr <= '0;
        wrPtr <= '0;
        cnt   <= '0;
      end else begin
        if (pushHere)
          wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
        if (popHere)
          rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
        cnt <= cnt + CNT_W'(pushHere) - CNT_W'(popHere);
      end
    end

    assign headAddr[b] = mem[rdPtr];
    assign emptyVec[b] = (cnt == '0);
    assign fullVec[b]  = (cnt == CNT_W'(DEPTH));

    // Outstanding-miss occupancy for this bank
    assign incHere = allocValid && (allocBank == BANK_W'(b));
    assign decHere = freeValid && (freeBank == BANK_W'(b)) && ((occ != '0) || incHere);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ <= '0;
      end else if (incHere && !decHere && (occ != OCC_W'(MSHR_ENTRIES))) begin
        occ <= occ + OCC_W'(1);
      end else if (decHere && !incHere) begin
        occ <= occ - OCC_W'(1);
      end
    end

    assign occVec[b] = occ;
  end
endmodule

// File: rtl/prefetch_issue_arb.sv
module prefetch_issue_arb
  import pia_pkg::*;
#(
  parameter int NUM_BANKS    = 8,
  parameter int FIFO_DEPTH   = 4,
  parameter int ADDR_W       = 32,
  parameter int MSHR_ENTRIES = 32,
  parameter int INTERVAL     = 100000,
  parameter int LOW_PCT      = 40,
  parameter int HIGH_PCT     = 85,
  parameter int TH_LOW       = 1,
  parameter int TH_MID       = 7,
  parameter int TH_HIGH      = 27
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pfValid,
  input  logic [ADDR_W-1:0]            pfAddr,
  input  logic [$clog2(NUM_BANKS)-1:0] pfBank,
  output logic                         pfReady,
  input  logic                         allocValid,
  input  logic [$clog2(NUM_BANKS)-1:0] allocBank,
  input  logic                         freeValid,
  input  logic [$clog2(NUM_BANKS)-1:0] freeBank,
  input  logic                         mshrFreeAvail,
  input  logic                         usefulEvt,
  input  logic                         issuedEvt,
  output logic                         issueValid,
  input  logic                         issueReady,
  output logic [ADDR_W-1:0]            issueAddr,
  output logic [$clog2(NUM_BANKS)-1:0] issueBank
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int OCC_W  = $clog2(MSHR_ENTRIES + 1);

  arbStrobes_t                     strobes;
  accLevel_t                       level;
  logic [NUM_BANKS-1:0][ADDR_W-1:0] headAddr;
  logic [NUM_BANKS-1:0]            emptyVec, fullVec;
  logic [NUM_BANKS-1:0][OCC_W-1:0] occVec;
  logic [BANK_W-1:0]               selBank;
  logic [OCC_W-1:0]                sendThresh;

  pia_acc_est #(
    .INTERVAL(INTERVAL), .LOW_PCT(LOW_PCT), .HIGH_PCT(HIGH_PCT)
  ) acc_i (
    .clk(clk), .rst_n(rst_n), .usefulEvt(usefulEvt), .issuedEvt(issuedEvt), .level(level)
  );

  pia_ctrl #(
    .NUM_BANKS(NUM_BANKS), .OCC_W(OCC_W), .BANK_W(BANK_W),
    .TH_LOW(TH_LOW), .TH_MID(TH_MID), .TH_HIGH(TH_HIGH)
  ) ctrl_i (
    .level(level), .occVec(occVec), .emptyVec(emptyVec), .fullVec(fullVec),
    .pfValid(pfValid), .pfBank(pfBank), .mshrFreeAvail(mshrFreeAvail),
    .issueReady(issueReady), .strobes(strobes), .selBank(selBank),
    .issueValid(issueValid), .pfReady(pfReady), .sendThresh(sendThresh)
  );

  pia_datapath #(
    .NUM_BANKS(NUM_BANKS), .DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W),
    .OCC_W(OCC_W), .BANK_W(BANK_W), .MSHR_ENTRIES(MSHR_ENTRIES)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .pushBank(pfBank), .pushAddr(pfAddr),
    .popBank(selBank), .allocValid(allocValid), .allocBank(allocBank),
    .freeValid(freeValid), .freeBank(freeBank), .headAddr(headAddr),
    .emptyVec(emptyVec), .fullVec(fullVec), .occVec(occVec)
  );

  assign issueAddr = headAddr[selBank];
  assign issueBank = selBank;
endmodule

// File: rtl/pia_checker.sv
module pia_checker #(
  parameter int NUM_BANKS    = 8,
  parameter int BANK_W       = 3,
  parameter int OCC_W        = 6,
  parameter int MSHR_ENTRIES = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            pfValid,
  input logic                            pfReady,
  input logic [BANK_W-1:0]               pfBank,
  input logic                            issueValid,
  input logic [BANK_W-1:0]               issueBank,
  input logic                            mshrFreeAvail,
  input logic [NUM_BANKS-1:0][OCC_W-1:0] occVec,
  input logic [NUM_BANKS-1:0]            emptyVec,
  input logic [OCC_W-1:0]                sendThresh
);
  logic [OCC_W-1:0] minOcc;

  always_comb begin
    minOcc = '1;
    for (int b = 0; b < NUM_BANKS; b++)
      if (!emptyVec[b] && (occVec[b] <= sendThresh) && (occVec[b] < minOcc))
        minOcc = occVec[b];
  end

  a_r6_no_issue_without_mshr: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid |-> mshrFreeAvail);

  a_r4_issue_within_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid |-> (occVec[issueBank] <= sendThresh));

  a_r5_min_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid |-> (occVec[issueBank] == minOcc));

  a_r1_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (pfValid && pfReady) |=> !emptyVec[$past(pfBank)]);

  a_r10_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!issueValid && pfReady));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_occ
    a_r3_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      occVec[b] <= OCC_W'(MSHR_ENTRIES));
  end
endmodule

bind prefetch_issue_arb pia_checker #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .OCC_W(OCC_W), .MSHR_ENTRIES(MSHR_ENTRIES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pfValid(pfValid), .pfReady(pfReady), .pfBank(pfBank),
  .issueValid(issueValid), .issueBank(issueBank), .mshrFreeAvail(mshrFreeAvail),
  .occVec(occVec), .emptyVec(emptyVec), .sendThresh(sendThresh)
);

// File: tb/prefetch_issue_arb_tb_top.sv
`timescale 1ns/1ps
module prefetch_issue_arb_tb_top;
  localparam int NB = 8;
  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam int IV = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pfValid = 0, allocValid = 0, freeValid = 0, mshrFreeAvail = 1;
  logic usefulEvt = 0, issuedEvt = 0, issueReady = 0;
  logic [AW-1:0] pfAddr = '0;
  logic [2:0] pfBank = '0, allocBank = '0, freeBank = '0;
  logic pfReady, issueValid;
  logic [AW-1:0] issueAddr;
  logic [2:0] issueBank;
  int checks = 0, errors = 0, edgeCnt = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edgeCnt <= 0;
    else edgeCnt <= edgeCnt + 1;
  end

  prefetch_issue_arb #(.NUM_BANKS(NB), .FIFO_DEPTH(DEPTH), .ADDR_W(AW), .INTERVAL(IV)) dut_i (
    .clk(clk), .rst_n(rst_n), .pfValid(pfValid), .pfAddr(pfAddr), .pfBank(pfBank),
    .pfReady(pfReady), .allocValid(allocValid), .allocBank(allocBank),
    .freeValid(freeValid), .freeBank(freeBank), .mshrFreeAvail(mshrFreeAvail),
    .usefulEvt(usefulEvt), .issuedEvt(issuedEvt), .issueValid(issueValid),
    .issueReady(issueReady), .issueAddr(issueAddr), .issueBank(issueBank)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 0; pfValid = 0; allocValid = 0; freeValid = 0; issueReady = 0;
    usefulEvt = 0; issuedEvt = 0; mshrFreeAvail = 1; pfBank = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
  endtask

  task automatic push(input int b, input logic [31:0] a);
    pfValid = 1; pfBank = 3'(b); pfAddr = a; step(); pfValid = 0;
  endtask

  task automatic allocN(input int b, input int n);
    allocValid = 1; allocBank = 3'(b); repeat (n) step(); allocValid = 0;
  endtask

  task automatic freeN(input int b, input int n);
    freeValid = 1; freeBank = 3'(b); repeat (n) step(); freeValid = 0;
  endtask

  task automatic popOne();
    issueReady = 1; step(); issueReady = 0; #1;
  endtask

  task automatic evts(input int useful, input int issued);
    for (int i = 0; i < issued; i++) begin
      issuedEvt = 1; usefulEvt = (i < useful); step();
    end
    issuedEvt = 0; usefulEvt = 0;
  endtask

  task automatic waitEdges(input int n);
    while (edgeCnt < n) @(negedge clk);
    #1;
  endtask

  // Raise bank 0 occupancy to thr, queue one prefetch, expect it offered; one more alloc blocks it
  task automatic probeThresh(input string tag, input int thr);
    allocN(0, thr);
    push(0, 32'hA000_0000 + thr);
    chk({tag, " offered at threshold"}, issueValid, 1);
    allocN(0, 1);
    chk({tag, " blocked above threshold"}, issueValid, 0);
  endtask

  task automatic t_reset();
    doReset();
    chk("R10 issueValid after reset", issueValid, 0);
    chk("R10 pfReady after reset", pfReady, 1);
  endtask

  task automatic t_order();
    doReset();
    push(2, 32'h100); push(2, 32'h200); push(2, 32'h300);
    chk("R1 head bank", issueBank, 2);
    chk("R1 head addr", issueAddr, 32'h100);
    step(); step(); step();
    chk("R9 held while not ready", issueAddr, 32'h100);
    chk("R9 valid held", issueValid, 1);
    popOne();
    chk("R1 second addr", issueAddr, 32'h200);
    popOne();
    chk("R1 third addr", issueAddr, 32'h300);
    popOne();
    chk("R9 drained", issueValid, 0);
  endtask

  task automatic t_full();
    doReset();
    for (int i = 0; i < DEPTH; i++) push(5, 32'h50 + i);
    pfBank = 5; #1;
    chk("R2 ready low when full", pfReady, 0);
    pfBank = 2; #1;
    chk("R2 other bank ready", pfReady, 1);
    push(5, 32'hBAD);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 stored entry", issueAddr, 32'h50 + i);
      popOne();
    end
    chk("R2 rejected entry not offered", issueValid, 0);
  endtask

  task automatic t_gate();
    doReset();
    push(4, 32'h44);
    mshrFreeAvail = 0; #1;
    chk("R6 no issue without free entry", issueValid, 0);
    mshrFreeAvail = 1; #1;
    chk("R6 issue with free entry", issueValid, 1);
  endtask

  task automatic t_select();
    doReset();
    allocN(1, 1);
    push(1, 32'h11); push(6, 32'h66); push(3, 32'h33);
    chk("R5 min occupancy lowest index", issueBank, 3);
    popOne();
    chk("R5 next min occupancy", issueBank, 6);
    allocValid = 1; allocBank = 6; freeValid = 1; freeBank = 6; step();
    allocValid = 0; freeValid = 0; #1;
    chk("R3 alloc and free cancel", issueBank, 6);
    freeN(6, 1);
    allocN(6, 1);
    chk("R3 free at zero ignored, tie to lower bank", issueBank, 1);
    allocN(1, 1);
    chk("R4 bank over threshold skipped", issueBank, 6);
    freeN(1, 1);
    chk("R3 free lowers occupancy", issueBank, 1);
  endtask

  task automatic t_acc_reset_low();
    doReset();
    probeThresh("R7 reset class low", 1);
  endtask

  task automatic t_acc_mid();
    doReset();
    evts(4, 10);
    waitEdges(IV);
    probeThresh("R7 40 percent gives mid", 7);
  endtask

  task automatic t_acc_high();
    doReset();
    evts(17, 20);
    waitEdges(IV);
    probeThresh("R7 85 percent gives high", 27);
  endtask

  task automatic t_acc_clear();
    doReset();
    evts(9, 10);
    waitEdges(IV + 2);
    evts(3, 10);
    waitEdges(2 * IV);
    probeThresh("R8 counts cleared, new low class", 1);
  endtask

  task automatic t_acc_keep();
    doReset();
    evts(4, 10);
    waitEdges(2 * IV);
    probeThresh("R8 empty interval keeps class", 7);
  endtask

  initial begin
    t_reset();
    t_order();
    t_full();
    t_gate();
    t_select();
    t_acc_reset_low();
    t_acc_mid();
    t_acc_high();
    t_acc_clear();
    t_acc_keep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule